// File: doc/BRIEF.md
# Space Vector PWM Gate Generator

This block drives the six gates of a three-leg, two-level inverter by space vector modulation. It takes two inputs: a reference angle in fixed-point form and a modulation index. From the angle it finds which of the six 60-degree sectors of the switching-vector hexagon holds the reference, and where the reference sits inside that sector. From these it computes how long each of the two neighbouring active vectors is applied. The remainder of the period goes to the zero vectors. The all-low zero state sits at the period edges and the all-high zero state sits at the period centre, and the two get equal time.

The dwell times become per-phase compare levels against a symmetric up/down ramp. Each upper gate is high while the ramp is at or above the compare level for its phase, and each lower gate is its complement. Angle and modulation index are sampled only at the ramp's zero point at the end of a period. This means a half-finished pattern never mixes two references. The controller can update the inputs at any time.

The angle counts steps of 3.75 degrees (16 steps per sector, 96 per turn). The modulation index is an unsigned fraction of 2^M_W.

Top module: `svpwm_gate_gen`

## Requirements
- R1: The sector is angle/16 + 1 (1 to 6), and the in-sector step is angle mod 16. For angles 96 and above, 96 is subtracted first, so the result is taken modulo 96. The sector output shows the sector in use during the current period.
- R2: The ramp counts 0 up to RAMP_TOP-1 and back down to 0, so each value occurs twice and a period is 2*RAMP_TOP cycles. Angle and index are captured only on the edge that ends a period. A period's outputs and sector therefore reflect the inputs held just before that period began, and the sector does not change within a period.
- R3: With m = index/2^M_W, T1 = m*sin(60deg - theta)*RAMP_TOP and T2 = m*sin(theta)*RAMP_TOP, where theta = step*3.75deg. Let h = (RAMP_TOP - T1 - T2)/2. Each phase's upper gate is high for 2*on cycles per period, within 5 cycles. The value of on is given per sector, listed as (a, b, c):
  - sector 1: (T1+T2+h, T2+h, h)
  - sector 2: (T1+h, T1+T2+h, h)
  - sector 3: (h, T1+T2+h, T2+h)
  - sector 4: (h, T1+h, T1+T2+h)
  - sector 5: (T2+h, h, T1+T2+h)
  - sector 6: (T1+T2+h, h, T1+h)
- R4: A modulation index above round(0.866*2^M_W) (222 for M_W = 8) is treated as exactly that value.
- R5: The lower gate of each phase is always the inverse of its upper gate. Bit 0 is phase a, bit 1 is phase b and bit 2 is phase c.
- R6: When the ramp is at 0, all upper gates are low (all-low zero vector). After the first load, all upper gates are high at the ramp peak (all-high zero vector).
- R7: Each upper gate changes state at most twice within a period.
- R8: Within a period, the phase that is high in both active vectors rises first. The phase that is high in neither rises last. In odd sectors this applies vector k before vector k+1; in even sectors the order is reversed, so that only one phase switches at each vector change.
- R9: Under reset, the upper gates are 000, the lower gates are 111 and the sector is 1. In the first period after reset every upper gate stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| angle_i | input | ANG_W | Reference angle in 3.75-degree steps |
| mindex_i | input | M_W | Modulation index, fraction of 2^M_W |
| gate_hi_o | output | 3 | Upper gates, bit 0 = phase a |
| gate_lo_o | output | 3 | Lower gates, complement of the upper gates |
| sector_o | output | 3 | Sector applied in the current period (1 to 6) |

## Verification
Inputs placed on the ports during one period take effect only in the next period. That period begins on the edge after the ramp's second zero sample and lasts 2*RAMP_TOP cycles.

The bench counts cycles from the release of reset and changes the inputs on the first sample of each period. Over the same period it gathers high-times, transitions, first-rise positions and sector values, and it compares these against the inputs it applied one period earlier. All outputs are registered, so each sample taken at a falling edge belongs to exactly one ramp value. The single-sample checks at the zero point and the peak are made at bench-computed positions within the period.

// File: rtl/svpwm_pkg.sv
`timescale 1ns/1ps
package svpwm_pkg;

    // steps per 60-degree sector, as a power of two
    localparam int SUB_BITS  = 4;
    localparam int SUB_STEPS = 1 << SUB_BITS;
    localparam int SECTORS   = 6;
    // sine samples are fractions of 2^SIN_W
    localparam int SIN_W     = 8;

    typedef logic [2:0] sector_t;

    // sin(k * 60deg / SUB_STEPS) scaled by 2^SIN_W, k = 0..SUB_STEPS
    function automatic logic [SIN_W-1:0] sin_step(input logic [SUB_BITS:0] k);
        logic [SIN_W-1:0] v;
        case (k)
            5'd0:    v = 8'd0;
            5'd1:    v = 8'd17;
            5'd2:    v = 8'd33;
            5'd3:    v = 8'd50;
            5'd4:    v = 8'd66;
            5'd5:    v = 8'd82;
            5'd6:    v = 8'd98;
            5'd7:    v = 8'd113;
            5'd8:    v = 8'd128;
            5'd9:    v = 8'd142;
            5'd10:   v = 8'd156;
            5'd11:   v = 8'd169;
            5'd12:   v = 8'd181;
            5'd13:   v = 8'd192;
            5'd14:   v = 8'd203;
            5'd15:   v = 8'd213;
            default: v = 8'd222;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/svpwm_sector.sv
`timescale 1ns/1ps
module svpwm_sector
    import svpwm_pkg::*;
#(
    parameter int ANG_W = 7
) (
    input  logic [ANG_W-1:0]    angle_i,
    output sector_t             sector_o,
    output logic [SUB_BITS-1:0] step_o
);

    localparam int FULL_TURN = SECTORS * SUB_STEPS;

    logic [ANG_W-1:0] wrapped;
    logic [2:0]       passed;

    always_comb begin
        wrapped = ANG_W'(int'(angle_i) % FULL_TURN);
        passed  = 3'd0;
        for (int i = 1; i < SECTORS; i++) begin
            if (int'(wrapped) >= i * SUB_STEPS) begin
                passed = passed + 3'd1;
            end
        end
        sector_o = passed + 3'd1;
        step_o   = wrapped[SUB_BITS-1:0];
    end

endmodule

// File: rtl/svpwm_dwell.sv
`timescale 1ns/1ps
module svpwm_dwell
    import svpwm_pkg::*;
#(
    parameter int M_W      = 8,
    parameter int RAMP_TOP = 64,
    parameter int CNT_W    = 7
) (
    input  logic [M_W-1:0]           mindex_i,
    input  sector_t                  sector_i,
    input  logic [SUB_BITS-1:0]      step_i,
    output logic [2:0][CNT_W-1:0]    on_o
);

    localparam int M_MAX_I = (866 * (1 << M_W) + 500) / 1000;
    localparam logic [M_W-1:0] M_MAX = M_W'(M_MAX_I);
    localparam int PW = M_W + SIN_W + CNT_W + 1;

    logic [M_W-1:0]   m_sat;
    logic [PW-1:0]    prod_lead;
    logic [PW-1:0]    prod_lag;
    logic [CNT_W-1:0] t_lead;
    logic [CNT_W-1:0] t_lag;
    logic [CNT_W-1:0] t_zero;
    logic [CNT_W-1:0] half_z;
    logic [CNT_W-1:0] both;

    always_comb begin
        m_sat     = (mindex_i > M_MAX) ? M_MAX : mindex_i;
        prod_lead = PW'(m_sat)
                  * PW'(sin_step(5'(SUB_STEPS) - {1'b0, step_i}))
                  * PW'(RAMP_TOP);
        prod_lag  = PW'(m_sat) * PW'(sin_step({1'b0, step_i})) * PW'(RAMP_TOP);
        t_lead    = CNT_W'(prod_lead >> (M_W + SIN_W));
        t_lag     = CNT_W'(prod_lag >> (M_W + SIN_W));
        t_zero    = CNT_W'(RAMP_TOP) - t_lead - t_lag;
        half_z    = t_zero >> 1;
        both      = t_lead + t_lag + half_z;
        case (sector_i)
            3'd1:    on_o = {half_z, t_lag + half_z, both};
            3'd2:    on_o = {half_z, both, t_lead + half_z};
            3'd3:    on_o = {t_lag + half_z, both, half_z};
            3'd4:    on_o = {both, t_lead + half_z, half_z};
            3'd5:    on_o = {both, half_z, t_lag + half_z};
            default: on_o = {t_lead + half_z, half_z, both};
        endcase
    end

endmodule

// File: rtl/svpwm_gate_gen.sv
`timescale 1ns/1ps
module svpwm_gate_gen
    import svpwm_pkg::*;
#(
    parameter int ANG_W    = 7,
    parameter int M_W      = 8,
    parameter int RAMP_TOP = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ANG_W-1:0] angle_i,
    input  logic [M_W-1:0]   mindex_i,
    output logic [2:0]       gate_hi_o,
    output logic [2:0]       gate_lo_o,
    output logic [2:0]       sector_o
);

    localparam int CNT_W = $clog2(RAMP_TOP + 1);

    typedef struct packed {
        logic [CNT_W-1:0]        ramp;
        logic                    down;
        logic [2:0][CNT_W-1:0]   cmp;
        sector_t                 sector;
        logic [2:0]              hi;
        logic [2:0]              lo;
    } state_t;

    state_t                state_d, state_q;
    sector_t               sector_c;
    logic [SUB_BITS-1:0]   step_c;
    logic [2:0][CNT_W-1:0] on_c;
    logic                  at_bound;

    svpwm_sector #(.ANG_W(ANG_W)) u_sector (
        .angle_i  (angle_i),
        .sector_o (sector_c),
        .step_o   (step_c)
    );

    svpwm_dwell #(.M_W(M_W), .RAMP_TOP(RAMP_TOP), .CNT_W(CNT_W)) u_dwell (
        .mindex_i (mindex_i),
        .sector_i (sector_c),
        .step_i   (step_c),
        .on_o     (on_c)
    );

    always_comb begin
        state_d  = state_q;
        at_bound = state_q.down && (state_q.ramp == '0);
        if (!state_q.down) begin
            if (state_q.ramp == CNT_W'(RAMP_TOP - 1)) begin
                state_d.down = 1'b1;
            end else begin
                state_d.ramp = state_q.ramp + 1'b1;
            end
        end else begin
            if (state_q.ramp == '0) begin
                state_d.down = 1'b0;
            end else begin
                state_d.ramp = state_q.ramp - 1'b1;
            end
        end
        if (at_bound) begin
            for (int i = 0; i < 3; i++) begin
                state_d.cmp[i] = CNT_W'(RAMP_TOP) - on_c[i];
            end
            state_d.sector = sector_c;
        end
        for (int i = 0; i < 3; i++) begin
            state_d.hi[i] = (state_d.ramp >= state_d.cmp[i]);
        end
        state_d.lo = ~state_d.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ramp   <= '0;
            state_q.down   <= 1'b0;
            state_q.cmp    <= {3{CNT_W'(RAMP_TOP)}};
            state_q.sector <= 3'd1;
            state_q.hi     <= 3'b000;
            state_q.lo     <= 3'b111;
        end else begin
            state_q <= state_d;
        end
    end

    assign gate_hi_o = state_q.hi;
    assign gate_lo_o = state_q.lo;
    assign sector_o  = state_q.sector;

endmodule

// File: rtl/svpwm_chk.sv
`timescale 1ns/1ps
module svpwm_chk #(
    parameter int TOP   = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] ramp,
    input logic             down,
    input logic [2:0]       gate_hi,
    input logic [2:0]       gate_lo,
    input logic [2:0]       sector
);

    logic loaded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded <= 1'b0;
        end else if (down && ramp == '0) begin
            loaded <= 1'b1;
        end
    end

    // R5
    complementary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_lo == ~gate_hi);

    // R1
    sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector >= 3'd1 && sector <= 3'd6);

    // R2
    sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(down && ramp == '0) |=> $stable(sector));

    // R2
    ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ramp) < TOP);

    // R6
    edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp == '0 |-> gate_hi == 3'b000);

    // R6
    peak_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && int'(ramp) == TOP - 1) |-> gate_hi == 3'b111);

endmodule

bind svpwm_gate_gen svpwm_chk #(.TOP(RAMP_TOP), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ramp    (state_q.ramp),
    .down    (state_q.down),
    .gate_hi (state_q.hi),
    .gate_lo (state_q.lo),
    .sector  (state_q.sector)
);

// File: tb/svpwm_gate_gen_test.sv
`timescale 1ns/1ps
module svpwm_gate_gen_test;

    localparam int TOP    = 64;
    localparam int PERIOD = 2 * TOP;
    localparam int TOL    = 5;
    localparam real PI    = 3.14159265358979;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] angle = 7'd0;
    logic [7:0] mindex = 8'd0;
    logic [2:0] g_hi;
    logic [2:0] g_lo;
    logic [2:0] sec;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int cnt_hi [3];
    int trans  [3];
    int rise   [3];
    bit comp_bad;
    bit sec_moved;
    bit edge_bad;
    bit peak_bad;
    logic [2:0] sec_first;

    svpwm_gate_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .angle_i   (angle),
        .mindex_i  (mindex),
        .gate_hi_o (g_hi),
        .gate_lo_o (g_lo),
        .sector_o  (sec)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // collect one full period; the first sample is the current state
    task automatic run_period();
        logic [2:0] prev;
        for (int p = 0; p < 3; p++) begin
            cnt_hi[p] = 0;
            trans[p]  = 0;
            rise[p]   = PERIOD;
        end
        comp_bad  = 0;
        sec_moved = 0;
        edge_bad  = 0;
        peak_bad  = 0;
        sec_first = sec;
        prev      = g_hi;
        for (int n = 0; n < PERIOD; n++) begin
            if (g_lo != ~g_hi) comp_bad = 1;
            if (sec != sec_first) sec_moved = 1;
            if ((n == 0 || n == PERIOD - 1) && g_hi != 3'b000) edge_bad = 1;
            if ((n == TOP - 1 || n == TOP) && g_hi != 3'b111) peak_bad = 1;
            for (int p = 0; p < 3; p++) begin
                if (g_hi[p]) cnt_hi[p]++;
                if (n > 0 && g_hi[p] != prev[p]) trans[p]++;
                if (g_hi[p] && rise[p] == PERIOD) rise[p] = n;
            end
            prev = g_hi;
            @(negedge clk);
        end
    endtask

    task automatic judge(input int a, input int m);
        int    aw, s, st, lead, trail, mid;
        real   meff, t1, t2, h, onv[3];
        string rq;
        aw   = a % 96;
        s    = aw / 16 + 1;
        st   = aw % 16;
        meff = ((m > 222) ? 222.0 : real'(m)) / 256.0;
        t1   = meff * $sin((60.0 - st * 3.75) * PI / 180.0) * TOP;
        t2   = meff * $sin(st * 3.75 * PI / 180.0) * TOP;
        h    = (TOP - t1 - t2) / 2.0;
        case (s)
            1: begin onv[0] = t1 + t2 + h; onv[1] = t2 + h; onv[2] = h; lead = 0; trail = 2; end
            2: begin onv[0] = t1 + h; onv[1] = t1 + t2 + h; onv[2] = h; lead = 1; trail = 2; end
            3: begin onv[0] = h; onv[1] = t1 + t2 + h; onv[2] = t2 + h; lead = 1; trail = 0; end
            4: begin onv[0] = h; onv[1] = t1 + h; onv[2] = t1 + t2 + h; lead = 2; trail = 0; end
            5: begin onv[0] = t2 + h; onv[1] = h; onv[2] = t1 + t2 + h; lead = 2; trail = 1; end
            default: begin onv[0] = t1 + t2 + h; onv[1] = h; onv[2] = t1 + h; lead = 0; trail = 1; end
        endcase
        mid = 3 - lead - trail;
        rq  = (m > 222) ? "R4" : "R3";
        // R1 sector decode and R2 capture at the period boundary
        check(sec_first == 3'(s), (a >= 96) ? "R1 wrap" : "R1", "sector",
              int'(sec_first), s);
        check(!sec_moved, "R2", "sector moved in period", int'(sec_moved), 0);
        for (int p = 0; p < 3; p++) begin
            int e;
            e = int'(2.0 * onv[p] + 0.5);
            check(cnt_hi[p] >= e - TOL && cnt_hi[p] <= e + TOL, rq,
                  $sformatf("high cycles a%0d m%0d phase%0d", a, m, p), cnt_hi[p], e);
            // R7 at most two transitions
            check(trans[p] <= 2, "R7", $sformatf("transitions phase%0d", p), trans[p], 2);
        end
        // R5 complementary, R6 zero vectors at edge and peak
        check(!comp_bad, "R5", "lower not inverse of upper", int'(comp_bad), 0);
        check(!edge_bad, "R6", "upper high at ramp zero", int'(edge_bad), 0);
        check(!peak_bad, "R6", "upper low at ramp peak", int'(peak_bad), 0);
        // R8 rise order
        check(rise[lead] <= rise[mid] && rise[mid] <= rise[trail], "R8",
              $sformatf("rise order sector%0d lead/trail", s), rise[lead], rise[trail]);
    endtask

    initial begin
        int pa, pm;
        bit have;
        repeat (3) @(negedge clk);
        // R9 reset values
        check(g_hi == 3'b000, "R9", "reset upper", int'(g_hi), 0);
        check(g_lo == 3'b111, "R9", "reset lower", int'(g_lo), 7);
        check(sec == 3'd1, "R9", "reset sector", int'(sec), 1);
        rst_n = 1'b1;
        have  = 0;
        pa    = 0;
        pm    = 0;
        for (int t = 0; t < 4 * 96 + 32 + 1; t++) begin
            int na, nm;
            if (t < 4 * 96) begin
                na = t % 96;
                case (t / 96)
                    0: nm = 0;
                    1: nm = 100;
                    2: nm = 222;
                    default: nm = 255;
                endcase
            end else begin
                na = 96 + (t - 4 * 96) % 32;
                nm = 150;
            end
            angle  = 7'(na);
            mindex = 8'(nm);
            run_period();
            if (have) begin
                judge(pa, pm);
            end else begin
                // R9 first period after reset stays low
                check(cnt_hi[0] + cnt_hi[1] + cnt_hi[2] == 0, "R9",
                      "first period upper high cycles",
                      cnt_hi[0] + cnt_hi[1] + cnt_hi[2], 0);
            end
            pa   = na;
            pm   = nm;
            have = 1;
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog expired actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule